// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the digital control front end of a programmable-gain line driver. A host loads a gain word over a three-wire serial link made of an active-low load-enable, a serial clock and a serial data line. Two further active-low pins choose the power mode. All five pins are asynchronous to the block. The block samples them with its own system clock through two-flop synchronizers and detects their edges in that clock domain.

A falling edge on the enable line opens a load window. During the window, each rising edge of the serial clock shifts one data bit into a 7-bit register, most significant bit first. The host sends 8 bits, so the leading bit drops off the top of the register. The rising edge of the enable line copies the register into the gain latch in a single step. The latched code is decoded into a coarse attenuation step and a fine vernier step. The block also reports the gain in quarter-dB units and flags codes above the valid range. Above that range the gain follows a repeating sawtooth instead of saturating.

The mode output is plain control. It shows transmit, between-burst (transmission disabled) or sleep, and sleep wins over between-burst. There is no streaming data path, so no valid/ready handshake and no back-pressure. The system clock must run at least four times as fast as the serial clock.

Top module: `gain_word_rx`

## Requirements
- R1: After reset the latched code is 0, the coarse and fine steps are 0, the gain output is -103 quarter-dB, the over-range flag is 0, and the mode (with both mode pins high) is transmit (encoding 0).
- R2: While `load_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into the 7-bit register, MSB first. Of an 8-bit word, only the last seven bits sent (bits 6..0) reach the register.
- R3: While `load_n` is high, serial clock edges do not change the register. This is seen at the ports when the next load window that has no clock edges latches the earlier contents unchanged.
- R4: The latched code changes only on a rising edge of `load_n`, which copies the whole register at once. During a load window the gain outputs keep their previous values.
- R5: For codes 0 to 71, `coarse_step` = code[6:3], `fine_step` = code[2:0], and `gain_qdb` = 110 - 3*(71 - code), a signed value in quarter-dB units.
- R6: For codes 72 to 127, `coarse_step` stays at 8 and `fine_step` = code[2:0]. `gain_qdb` = 110 - 3*(7 - code[2:0]), which is a sawtooth with a period of eight codes, and `over_range` is 1.
- R7: Bit 7 of the sent word has no effect: words w and w^8'h80 produce identical outputs.
- R8: `pwr_mode` is 2 (sleep) when `sleep_n` is low, whatever `txoff_n` is. It is 1 (between-burst) when only `txoff_n` is low, and 0 (transmit) when both pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low reset |
| load_n | input | 1 | Serial load enable; a fall opens a load window, a rise latches the word |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| txoff_n | input | 1 | Active-low between-burst request |
| sleep_n | input | 1 | Active-low sleep request, wins over txoff_n |
| gain_code | output | 7 | Latched gain code |
| coarse_step | output | 4 | Coarse attenuation step, saturating at 8 |
| fine_step | output | 3 | Fine vernier step |
| gain_qdb | output | 9 | Signed gain in quarter-dB units |
| over_range | output | 1 | Latched code is above 71 |
| pwr_mode | output | 2 | 0 transmit, 1 between-burst, 2 sleep |

## Verification
The bench applies eight-bit words with the top bit both set and clear. A design that kept the first bit sent, or decoded bit 7, would show a shifted or different code. It checks codes 72 and 127 on the sawtooth: a design that saturated the whole code, or let the coarse step run past 8, would report the wrong gain. It pulses the serial clock while the enable is high and then latches with an empty window, which exposes a register that shifts when it should not. It samples the outputs in the middle of a load to catch a latch that follows the register. The mode-pin combinations include both pins low, so a design that gave the power-down pin priority would report between-burst instead of sleep.

// File: rtl/gwr_pkg.sv
package gwr_pkg;
  // Power mode reported on pwr_mode
  typedef enum logic [1:0] {
    PM_TX    = 2'd0,
    PM_GAP   = 2'd1,
    PM_SLEEP = 2'd2
  } pmode_e;

  localparam int PIN_CNT = 5;
  // pin positions inside the synchronizer vector
  localparam int PIN_LOAD  = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_SDAT  = 2;
  localparam int PIN_TXOFF = 3;
  localparam int PIN_SLEEP = 4;
  // idle values the synchronizer takes in reset
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 5'b11001;
endpackage

// File: rtl/gwr_sync.sv
module gwr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gwr_shift.sv
module gwr_shift #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic [CODE_W-1:0] shreg,
  output logic [CODE_W-1:0] code_q,
  output logic              load_rise
);
  logic load_d;
  logic sclk_d;
  logic sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign load_rise = load_s & ~load_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_d <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      load_d <= load_s;
      sclk_d <= sclk_s;
    end
  end

  // shift only inside an open load window; oldest bit falls off the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (!load_s && sclk_rise)
      shreg <= {shreg[CODE_W-2:0], sdat_s};
  end

  // whole-register copy on the closing edge of the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code_q <= '0;
    else if (load_rise)
      code_q <= shreg;
  end
endmodule

// File: rtl/gwr_decode.sv
module gwr_decode #(
  parameter int CODE_W   = 7,
  parameter int FINE_W   = 3,
  parameter int MAX_CODE = 71,
  parameter int MAX_QDB  = 110,
  parameter int STEP_Q   = 3,
  parameter int GAIN_W   = 9,
  localparam int COARSE_W  = CODE_W - FINE_W,
  localparam int COARSE_MAX = MAX_CODE >> FINE_W
) (
  input  logic [CODE_W-1:0]        code,
  output logic [COARSE_W-1:0]      coarse,
  output logic [FINE_W-1:0]        fine,
  output logic signed [GAIN_W-1:0] gain_qdb,
  output logic                     over
);
  logic [COARSE_W-1:0] coarse_raw;
  int steps;
  int gain_i;

  always_comb begin
    coarse_raw = code[CODE_W-1:FINE_W];
    fine       = code[FINE_W-1:0];
    over       = (int'(code) > MAX_CODE);
    if (int'(coarse_raw) > COARSE_MAX)
      coarse = COARSE_W'(COARSE_MAX);
    else
      coarse = coarse_raw;
    steps    = int'(coarse) * (1 << FINE_W) + int'(fine);
    gain_i   = MAX_QDB - STEP_Q * (MAX_CODE - steps);
    gain_qdb = GAIN_W'(gain_i);
  end
endmodule

// File: rtl/gwr_mode.sv
module gwr_mode
  import gwr_pkg::*;
(
  input  logic       txoff_s,
  input  logic       sleep_s,
  output logic [1:0] mode
);
  pmode_e m;
  always_comb begin
    if (!sleep_s)      m = PM_SLEEP;
    else if (!txoff_s) m = PM_GAP;
    else               m = PM_TX;
    mode = m;
  end
endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx
  import gwr_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int FINE_W   = 3,
  parameter int MAX_CODE = 71,
  parameter int SYNC_STAGES = 2,
  parameter int GAIN_W   = 9,
  localparam int COARSE_W = CODE_W - FINE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_n,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     txoff_n,
  input  logic                     sleep_n,
  output logic [CODE_W-1:0]        gain_code,
  output logic [COARSE_W-1:0]      coarse_step,
  output logic [FINE_W-1:0]        fine_step,
  output logic signed [GAIN_W-1:0] gain_qdb,
  output logic                     over_range,
  output logic [1:0]               pwr_mode
);
  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_s;
  logic               load_s;
  logic               load_rise;
  logic [CODE_W-1:0]  shreg;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_LOAD]  = load_n;
    pins_raw[PIN_SCLK]  = ser_clk;
    pins_raw[PIN_SDAT]  = ser_dat;
    pins_raw[PIN_TXOFF] = txoff_n;
    pins_raw[PIN_SLEEP] = sleep_n;
  end

  gwr_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign load_s = pins_s[PIN_LOAD];

  gwr_shift #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_s(load_s), .sclk_s(pins_s[PIN_SCLK]), .sdat_s(pins_s[PIN_SDAT]),
    .shreg(shreg), .code_q(gain_code), .load_rise(load_rise)
  );

  gwr_decode #(.CODE_W(CODE_W), .FINE_W(FINE_W), .MAX_CODE(MAX_CODE),
               .GAIN_W(GAIN_W)) u_dec (
    .code(gain_code), .coarse(coarse_step), .fine(fine_step),
    .gain_qdb(gain_qdb), .over(over_range)
  );

  gwr_mode u_mode (
    .txoff_s(pins_s[PIN_TXOFF]), .sleep_s(pins_s[PIN_SLEEP]), .mode(pwr_mode)
  );
endmodule

// File: rtl/gwr_chk.sv
module gwr_chk #(
  parameter int CODE_W = 7,
  parameter int COARSE_W = 4,
  parameter int GAIN_W = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sleep_n,
  input logic                     txoff_n,
  input logic                     load_s,
  input logic                     load_rise,
  input logic [CODE_W-1:0]        shreg,
  input logic [CODE_W-1:0]        gain_code,
  input logic [COARSE_W-1:0]      coarse_step,
  input logic signed [GAIN_W-1:0] gain_qdb,
  input logic                     over_range,
  input logic [1:0]               pwr_mode
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  AST_NO_SHIFT_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && load_s) |=> $stable(shreg)); // R3
  AST_HOLD_OUTSIDE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !load_rise) |=> $stable(gain_code)); // R4
  AST_COPY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && load_rise) |=> (gain_code == $past(shreg))); // R2
  AST_SAWTOOTH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (coarse_step == COARSE_W'(8) && gain_qdb >= GAIN_W'(89))); // R6
  AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_qdb >= -GAIN_W'(103) && gain_qdb <= GAIN_W'(110))); // R5
  AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !$past(sleep_n, 1) && !$past(sleep_n, 2) && !$past(sleep_n, 3))
    |-> (pwr_mode == 2'd2)); // R8
  AST_GAP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && $past(sleep_n, 1) && $past(sleep_n, 2) && $past(sleep_n, 3)
     && !$past(txoff_n, 1) && !$past(txoff_n, 2) && !$past(txoff_n, 3))
    |-> (pwr_mode == 2'd1)); // R8
endmodule

bind gain_word_rx gwr_chk #(.CODE_W(CODE_W), .COARSE_W(COARSE_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .txoff_n(txoff_n),
  .load_s(load_s), .load_rise(load_rise), .shreg(shreg),
  .gain_code(gain_code), .coarse_step(coarse_step), .gain_qdb(gain_qdb),
  .over_range(over_range), .pwr_mode(pwr_mode)
);

// File: tb/sim_gain_word_rx.sv
`timescale 1ns/1ps
module sim_gain_word_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic txoff_n = 1'b1, sleep_n = 1'b1;
  logic [6:0] gain_code;
  logic [3:0] coarse_step;
  logic [2:0] fine_step;
  logic signed [8:0] gain_qdb;
  logic over_range;
  logic [1:0] pwr_mode;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gain_word_rx u0 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .txoff_n(txoff_n), .sleep_n(sleep_n), .gain_code(gain_code),
    .coarse_step(coarse_step), .fine_step(fine_step), .gain_qdb(gain_qdb),
    .over_range(over_range), .pwr_mode(pwr_mode)
  );

  // {word[7:0], txoff_n, sleep_n, expected code[6:0], expected mode[1:0]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {8'h00, 1'b1, 1'b1, 7'd0,   2'd0},
    {8'h47, 1'b1, 1'b1, 7'd71,  2'd0},
    {8'hC7, 1'b1, 1'b1, 7'd71,  2'd0},
    {8'h48, 1'b1, 1'b1, 7'd72,  2'd0},
    {8'h7F, 1'b1, 1'b1, 7'd127, 2'd0},
    {8'hFF, 1'b1, 1'b1, 7'd127, 2'd0},
    {8'h23, 1'b0, 1'b1, 7'd35,  2'd1},
    {8'hA3, 1'b0, 1'b0, 7'd35,  2'd2},
    {8'h50, 1'b1, 1'b0, 7'd80,  2'd2},
    {8'h15, 1'b1, 1'b1, 7'd21,  2'd0}
  };

  function automatic int ref_gain(input int code);
    int eff;
    eff = (code > 71) ? 64 + (code % 8) : code;
    return 110 - 3 * (71 - eff);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_code(input string req, input int code);
    chk({req, " code"},   int'(gain_code), code);
    chk({req, " coarse"}, int'(coarse_step), (code > 71) ? 8 : code / 8);
    chk({req, " fine"},   int'(fine_step), code % 8);
    chk({req, " gain"},   int'(gain_qdb), ref_gain(code));
    chk({req, " over"},   int'(over_range), (code > 71) ? 1 : 0);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b; ticks(4);
    ser_clk = 1'b1; ticks(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] w);
    load_n = 1'b0; ticks(6);
    for (int i = 7; i >= 0; i--) shift_bit(w[i]);
    ticks(4);
    load_n = 1'b1; ticks(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    ticks(5);
    rst_n = 1'b1;
    ticks(6);
    // R1 reset state
    chk_code("R1", 0);
    chk("R1 mode", int'(pwr_mode), 0);

    // R2 R5 R6 R7 R8 vector table
    for (int v = 0; v < NV; v++) begin
      txoff_n = VEC[v][10];
      sleep_n = VEC[v][9];
      send_word(VEC[v][18:11]);
      chk_code("R2/R5/R6/R7", int'(VEC[v][8:2]));
      chk("R8 mode", int'(pwr_mode), int'(VEC[v][1:0]));
    end

    // R3: clocks with load_n high must not shift (register holds 0x15)
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    load_n = 1'b0; ticks(8);
    load_n = 1'b1; ticks(8);
    chk_code("R3", 21);

    // R4: outputs hold during an open load window
    load_n = 1'b0; ticks(6);
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    ticks(4);
    chk_code("R4 mid-load", 21);
    for (int i = 0; i < 3; i++) shift_bit(1'b0);
    ticks(4);
    chk_code("R4 before rise", 21);
    load_n = 1'b1; ticks(8);
    chk_code("R4 after rise", 120);

    // R7: bit 7 set vs clear, same code
    send_word(8'hB0);
    chk_code("R7 hi", 48);
    send_word(8'h30);
    chk_code("R7 lo", 48);

    // R8: mode change on its own, latch untouched
    txoff_n = 1'b0; sleep_n = 1'b1; ticks(6);
    chk("R8 gap", int'(pwr_mode), 1);
    sleep_n = 1'b0; ticks(6);
    chk("R8 sleep wins", int'(pwr_mode), 2);
    txoff_n = 1'b1; sleep_n = 1'b1; ticks(6);
    chk("R8 tx", int'(pwr_mode), 0);

    // R1: reset mid-run clears the latch
    rst_n = 1'b0; ticks(3);
    rst_n = 1'b1; ticks(6);
    chk_code("R1 rerun", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule